// File: doc/BRIEF.md
# Decadic Bit Error Rate Classifier

This block sits behind a bit error rate checker. It receives one strobe for each checked bit, along with a flag that marks the bit as errored. From these it keeps a running classification of the error rate into decade bands. The result is a small band code plus a one-cycle pulse that marks each change of band. Downstream logic can use the pulse to log events or to raise alarms.

The block keeps one tracker for each decade threshold. The tracker for the 1-in-10^n threshold splits its observation span into a ring of bins, each covering 10^n checked bits. When a bin fills, the tracker overwrites the oldest bin and compares the total over the whole ring with a fixed count. With ten bins and a count of ten, a tracker looks at 10^(n+1) bits before deciding whether the rate is worse than 1 in 10^n. Coarse decades therefore react quickly and fine decades decide slowly but smoothly. The reported band is set by the coarsest decade whose threshold is exceeded.

The radix, the first exponent, the number of decades, the bins per ring and the count threshold are all parameters. The defaults cover thresholds 1 in 10^2 up to 1 in 10^7, which gives seven bands.

Top module: `ber_decade_classifier`

## Requirements
- R1: While rst_ni is low and just after it is released, band_o equals NUM_DEC (the best band) and band_chg_o is 0. All error history is discarded, so bits seen before the reset have no effect on later decisions.
- R2: A cycle adds to the counts only when bit_valid_i is 1. When bit_valid_i is 0, bit_err_i has no effect.
- R3: Decade k (k = 0 .. NUM_DEC-1) closes a sub-window after every RADIX^(FIRST_EXP+k) valid bits. It re-evaluates its decision only at that closing bit, and holds the decision in between.
- R4: When it re-evaluates, decade k is marked exceeded if and only if the number of errored bits among the last NUM_BINS sub-windows is greater than THRESH. Before NUM_BINS sub-windows have been seen, it uses all bits since reset.
- R5: The band code is the lowest k whose decade is exceeded, or NUM_DEC if none is. Code 0 means worse than 1 in RADIX^FIRST_EXP. Code NUM_DEC means better than 1 in RADIX^(FIRST_EXP+NUM_DEC-1).
- R6: band_o takes its new value one clock edge after the edge that accepts the closing bit.
- R7: band_chg_o is 1 for exactly one cycle, namely the first cycle in which band_o holds a value that differs from its previous value. It is never 1 otherwise.
- R8: An error flagged on the bit that closes a sub-window counts in that sub-window. When one bit closes the sub-windows of several decades, every one of those decades is updated from that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | One checked bit is presented in this cycle |
| bit_err_i | input | 1 | The presented bit was received in error |
| band_o | output | $clog2(NUM_DEC+1) | Current band code (0 = worst) |
| band_chg_o | output | 1 | One-cycle pulse when band_o changes |

## Verification
Because the sub-window counters are chained, one checked bit can close the sub-windows of every decade at once. If that bit is also errored, the update of all the rings and the resulting band change all happen on the same edge. The bench uses a small configuration with power-of-two sub-windows, so these coincident closes happen every few bits. It drives error densities and bursts that land errors on the closing bits. After every bit it compares the band and the pulse against a decade-by-decade recount of the error history held in the bench.

// File: rtl/ber_cls_pkg.sv
package ber_cls_pkg;
  function automatic int unsigned ipow(input int unsigned base, input int unsigned ex);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < ex; i++) r = r * base;
    return r;
  endfunction
endpackage

// File: rtl/ber_decade.sv
module ber_decade #(
  parameter int unsigned LEN      = 100,
  parameter int unsigned NUM_BINS = 10,
  parameter int unsigned THRESH   = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic err_i,
  output logic close_o,
  output logic exceed_o
);
  localparam int unsigned SAT   = THRESH + 1;
  localparam int unsigned CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam int unsigned BIN_W = $clog2(SAT + 1);
  localparam int unsigned SUM_W = $clog2(NUM_BINS * SAT + 1);
  localparam int unsigned PTR_W = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] ptr_q;
  logic [BIN_W-1:0] acc_q, acc_inc;
  logic [BIN_W-1:0] bins_q [NUM_BINS];
  logic [SUM_W-1:0] sum_q, sum_nxt;
  logic             exceed_q;

  assign close_o  = step_i && (cnt_q == CNT_W'(LEN - 1));
  assign exceed_o = exceed_q;

  // bins saturate just above threshold; the decision stays exact
  always_comb begin
    acc_inc = acc_q;
    if (err_i && (acc_q != BIN_W'(SAT))) acc_inc = acc_q + 1'b1;
    sum_nxt = sum_q - SUM_W'(bins_q[ptr_q]) + SUM_W'(acc_inc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ptr_q    <= '0;
      acc_q    <= '0;
      sum_q    <= '0;
      exceed_q <= 1'b0;
      for (int i = 0; i < int'(NUM_BINS); i++) bins_q[i] <= '0;
    end else begin
      if (step_i) cnt_q <= close_o ? '0 : cnt_q + 1'b1;
      if (close_o) begin
        bins_q[ptr_q] <= acc_inc;
        sum_q         <= sum_nxt;
        exceed_q      <= sum_nxt > SUM_W'(THRESH);
        acc_q         <= '0;
        ptr_q         <= (ptr_q == PTR_W'(NUM_BINS - 1)) ? '0 : ptr_q + 1'b1;
      end else begin
        acc_q <= acc_inc;
      end
    end
  end

  assert_exceed_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close_o |=> $stable(exceed_q));
  assert_ptr_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_o && ptr_q == PTR_W'(NUM_BINS - 1)) |=> (ptr_q == '0));
  assert_acc_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= BIN_W'(SAT));
  assert_acc_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> (acc_q == '0));
endmodule

// File: rtl/ber_band_sel.sv
module ber_band_sel #(
  parameter int unsigned NUM_DEC = 6,
  parameter int unsigned BAND_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_DEC-1:0] exceed_i,
  output logic [BAND_W-1:0] band_o,
  output logic              band_chg_o
);
  logic [BAND_W-1:0] band_q, band_nxt;
  logic              chg_q;

  always_comb begin
    band_nxt = BAND_W'(NUM_DEC);
    for (int k = int'(NUM_DEC) - 1; k >= 0; k--)
      if (exceed_i[k]) band_nxt = BAND_W'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      band_q <= BAND_W'(NUM_DEC);
      chg_q  <= 1'b0;
    end else begin
      band_q <= band_nxt;
      chg_q  <= band_nxt != band_q;
    end
  end

  assign band_o     = band_q;
  assign band_chg_o = chg_q;

  assert_chg_differs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    band_chg_o |-> (band_o != $past(band_o)));
  assert_hold_no_chg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !band_chg_o |-> $stable(band_o));
  assert_band_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    band_o <= BAND_W'(NUM_DEC));
  assert_worst_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_o == '0) |-> $past(exceed_i[0]));
endmodule

// File: rtl/ber_decade_classifier.sv
module ber_decade_classifier #(
  parameter int unsigned RADIX     = 10,
  parameter int unsigned FIRST_EXP = 2,
  parameter int unsigned NUM_DEC   = 6,
  parameter int unsigned NUM_BINS  = 10,
  parameter int unsigned THRESH    = 10,
  localparam int unsigned BAND_W   = $clog2(NUM_DEC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              bit_err_i,
  output logic [BAND_W-1:0] band_o,
  output logic              band_chg_o
);
  localparam int unsigned BASE_LEN = ber_cls_pkg::ipow(RADIX, FIRST_EXP);

  logic               err_w;
  logic [NUM_DEC-1:0] step_w, close_w, exceed_w;

  assign err_w = bit_valid_i & bit_err_i;

  // decade k+1 counts sub-window closes of decade k
  for (genvar k = 0; k < int'(NUM_DEC); k++) begin : g_dec
    if (k == 0) begin : g_first
      assign step_w[k] = bit_valid_i;
    end else begin : g_chain
      assign step_w[k] = close_w[k-1];
    end
    ber_decade #(
      .LEN      ((k == 0) ? BASE_LEN : RADIX),
      .NUM_BINS (NUM_BINS),
      .THRESH   (THRESH)
    ) u_dec (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step_w[k]),
      .err_i    (err_w),
      .close_o  (close_w[k]),
      .exceed_o (exceed_w[k])
    );
  end

  ber_band_sel #(
    .NUM_DEC (NUM_DEC),
    .BAND_W  (BAND_W)
  ) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exceed_i   (exceed_w),
    .band_o     (band_o),
    .band_chg_o (band_chg_o)
  );

  assert_idle_no_close_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |-> (close_w == '0));
  assert_exceed_only_at_close_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> $stable(exceed_w));
endmodule

// File: tb/ber_decade_classifier_tb.sv
module ber_decade_classifier_tb;
  localparam int NDEC = 3;
  localparam int NBIN = 4;
  localparam int THR  = 4;
  localparam int BW   = $clog2(NDEC + 1);
  localparam int MAXB = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic err = 1'b0;
  logic [BW-1:0] band;
  logic chg;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit hist [MAXB];
  int nb = 0;
  bit ex [NDEC];
  int exp_band = NDEC;
  int prev_band = NDEC;

  always #4 clk = ~clk;

  ber_decade_classifier #(
    .RADIX(2), .FIRST_EXP(1), .NUM_DEC(NDEC), .NUM_BINS(NBIN), .THRESH(THR)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(valid), .bit_err_i(err),
    .band_o(band), .band_chg_o(chg)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d nb=%0d", req, act, expv, nb);
    end
  endtask

  task automatic model_clear();
    nb = 0;
    for (int k = 0; k < NDEC; k++) ex[k] = 0;
    exp_band = NDEC;
    prev_band = NDEC;
  endtask

  task automatic model_bit(input bit e);
    hist[nb] = e;
    nb++;
    for (int k = 0; k < NDEC; k++) begin
      int s;
      s = 1 << (k + 1);
      if (nb % s == 0) begin
        int lo;
        int c;
        lo = nb - NBIN * s;
        if (lo < 0) lo = 0;
        c = 0;
        for (int i = lo; i < nb; i++) c += hist[i];
        ex[k] = (c > THR);
      end
    end
    exp_band = NDEC;
    for (int k = NDEC - 1; k >= 0; k--) if (ex[k]) exp_band = k;
  endtask

  // one valid bit, then an idle cycle with the error flag raised (R2)
  task automatic send_bit(input bit e);
    valid = 1'b1;
    err = e;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    err = 1'b1;
    check(chg == 1'b0, "R7 pulse width", chg, 0);
    @(posedge clk);
    @(negedge clk);
    model_bit(e);
    check(band == BW'(exp_band), "R4 R5 R6 R8 band", band, exp_band);
    check(chg == (exp_band != prev_band), "R7 change pulse", chg, int'(exp_band != prev_band));
    prev_band = exp_band;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    valid = 1'b0;
    err = 1'b1;
    repeat (3) @(negedge clk);
    check(band == BW'(NDEC), "R1 band in reset", band, NDEC);
    check(chg == 1'b0, "R1 pulse in reset", chg, 0);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    check(band == BW'(NDEC), "R1 band after reset", band, NDEC);
    check(chg == 1'b0, "R1 pulse after reset", chg, 0);
  endtask

  initial begin
    logic [7:0] lf;
    do_reset();
    // R2: idle cycles with the error flag high must not move the band
    repeat (40) @(negedge clk);
    check(band == BW'(NDEC), "R2 idle errors ignored", band, NDEC);
    for (int i = 0; i < 64; i++) send_bit(1'b0);
    for (int i = 0; i < 64; i++) send_bit(1'b1);
    for (int i = 0; i < 96; i++) send_bit(i % 3 == 0);
    for (int i = 0; i < 96; i++) send_bit(i % 6 == 0);
    for (int i = 0; i < 96; i++) send_bit(i % 10 == 0);
    for (int i = 0; i < 64; i++) send_bit(1'b0);
    // bursts placed on closing bits (R8)
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 7; i++) send_bit(1'b0);
      send_bit(1'b1);
    end
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    for (int i = 0; i < 48; i++) send_bit(1'b0);
    // R1: history before reset is forgotten
    for (int i = 0; i < 32; i++) send_bit(1'b1);
    do_reset();
    for (int i = 0; i < 40; i++) send_bit(1'b0);
    // pseudo-random densities
    lf = 8'h5a;
    for (int d = 0; d < 4; d++) begin
      for (int i = 0; i < 80; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        send_bit((lf & ((8'd1 << d) - 8'd1)) == 8'd0 ? 1'b1 : (lf[7:5] == 3'd0));
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule